// File: doc/BRIEF.md
# Cross-Halfword Multiply-Accumulate Unit

This execution unit performs one multiply-accumulate step for a 32-bit integer datapath. It multiplies the lower halfword of the first source word by the upper halfword of the second source word, then adds that product to the current destination value. The sum is formed one bit wider than the word.

The new destination value is returned as one of two forms. In modulo form it is the low word of the wide sum. In saturating form it is clamped to the nearest value the word can represent. Per-operation controls select the following:

- signed or unsigned arithmetic;
- modulo or saturating result;
- whether the overflow flag and the sticky summary-overflow flag are written;
- whether a 4-bit condition field is written.

The surrounding pipeline pulses `start` together with the operands and the control bits. One cycle later it reads the registered results, which are flagged by `valid`.

Top module: `xhalf_mac`

## Requirements
- R1: The multiplier operands are `a_in[15:0]` and `b_in[31:16]` (bit 0 is the LSB). No other bit of either source word affects any result.
- R2: With `is_signed`=1, both halfwords, the 32-bit product and `d_in` are sign-extended to a 33-bit sum. With `is_signed`=0, all of them are zero-extended.
- R3: With `saturate`=0, `d_out` receives bits 31:0 of the 33-bit sum.
- R4: With `saturate`=1 and signed arithmetic, a sum above 0x7FFF_FFFF stores 0x7FFF_FFFF, and a sum below -2^31 stores 0x8000_0000.
- R5: With `saturate`=1 and unsigned arithmetic, a sum above 0xFFFF_FFFF stores 0xFFFF_FFFF.
- R6: Overflow is declared in two cases: in signed mode when sum bits 32 and 31 differ, and in unsigned mode when sum bit 32 is set. `ov` reports this unsaturated overflow even when the stored value is clamped.
- R7: On a `start` with `rec_ov`=1, `ov` takes the overflow indication and `so` is ORed with it, which makes `so` sticky. On a `start` with `rec_ov`=0, `ov` and `so` keep their values.
- R8: `so_clear` clears `so` at the next edge. If `so_clear` arrives together with a recording `start`, the clear is applied first and then the new overflow is ORed in.
- R9: On a `start` with `rec_cond`=1, the condition field is written as follows: `cond[3]` = stored result negative, `cond[2]` = stored result positive, `cond[1]` = stored result zero (the stored word is read as signed), and `cond[0]` = `so` after this operation. On a `start` with `rec_cond`=0, `cond` keeps its value.
- R10: `valid` is high for exactly the one cycle after a `start` cycle. `d_out`, `ov` and `cond` hold their values until the next `start`.
- R11: While `rst` is high, every output is held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch one operation with the inputs of this cycle |
| a_in | input | 32 | First source word (low halfword used) |
| b_in | input | 32 | Second source word (high halfword used) |
| d_in | input | 32 | Current destination value (accumulator) |
| is_signed | input | 1 | 1 = signed arithmetic, 0 = unsigned |
| saturate | input | 1 | 1 = saturating result, 0 = modulo |
| rec_ov | input | 1 | Record overflow into `ov` and `so` |
| rec_cond | input | 1 | Record the condition field |
| so_clear | input | 1 | Clear the sticky summary-overflow flag |
| valid | output | 1 | Result valid, one cycle after `start` |
| d_out | output | 32 | New destination value |
| ov | output | 1 | Overflow flag |
| so | output | 1 | Sticky summary-overflow flag |
| cond | output | 4 | {negative, positive, zero, summary-overflow} |

## Verification
Every result of the unit is due exactly one clock edge after `start` is sampled. This applies to `d_out`, `ov`, `so`, `cond` and `valid`, and to `so_clear`, whose effect on `so` also lands at the next edge. The bench drives `start` for one cycle at a falling edge, drops it at the next falling edge, and samples all outputs at that moment, half a cycle after the capturing edge. To confirm that values are held, the bench changes the inputs with `start` low and samples again one cycle later. It also checks that `valid` has fallen by then.

// File: rtl/xmac_pkg.sv
package xmac_pkg;
  localparam int unsigned WORD = 32;
  localparam int unsigned HALF = WORD / 2;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic sumov;
  } xmac_cond_t;
endpackage

// File: rtl/xmac_mult.sv
module xmac_mult #(
  parameter int unsigned HALF = 16,
  localparam int unsigned PW = 2 * HALF
) (
  input  logic [HALF-1:0] a_half,
  input  logic [HALF-1:0] b_half,
  input  logic            is_signed,
  output logic [PW-1:0]   prod
);
  logic signed [PW-1:0] prod_s;
  logic        [PW-1:0] prod_u;

  always_comb begin
    prod_s = $signed(a_half) * $signed(b_half);
    prod_u = a_half * b_half;
    prod   = is_signed ? prod_s : prod_u;
  end
endmodule

// File: rtl/xmac_accum.sv
module xmac_accum #(
  parameter int unsigned WORD = 32,
  localparam int unsigned SW = WORD + 1
) (
  input  logic [WORD-1:0] prod,
  input  logic [WORD-1:0] dval,
  input  logic            is_signed,
  input  logic            saturate,
  output logic [WORD-1:0] result,
  output logic            ovf
);
  localparam logic [WORD-1:0] SMAX = {1'b0, {(WORD-1){1'b1}}};
  localparam logic [WORD-1:0] SMIN = {1'b1, {(WORD-1){1'b0}}};
  localparam logic [WORD-1:0] UMAX = {WORD{1'b1}};

  logic [SW-1:0]   sum;
  logic [WORD-1:0] clamp;

  always_comb begin
    sum = {is_signed & prod[WORD-1], prod} + {is_signed & dval[WORD-1], dval};
    if (is_signed) begin
      ovf   = sum[SW-1] ^ sum[WORD-1];
      clamp = sum[SW-1] ? SMIN : SMAX;
    end else begin
      ovf   = sum[SW-1];
      clamp = UMAX;
    end
    result = (saturate && ovf) ? clamp : sum[WORD-1:0];
  end
endmodule

// File: rtl/xhalf_mac.sv
module xhalf_mac
  import xmac_pkg::*;
#(
  parameter int unsigned W = WORD,
  localparam int unsigned H = W / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] d_in,
  input  logic         is_signed,
  input  logic         saturate,
  input  logic         rec_ov,
  input  logic         rec_cond,
  input  logic         so_clear,
  output logic         valid,
  output logic [W-1:0] d_out,
  output logic         ov,
  output logic         so,
  output logic [3:0]   cond
);
  logic [W-1:0] prod;
  logic [W-1:0] res;
  logic         ovf;
  logic         so_base;
  logic         so_next;
  xmac_cond_t   cond_next;
  logic         unused_halves;

  // R1: only the crossed halves reach the multiplier
  assign unused_halves = ^{a_in[W-1:H], b_in[H-1:0]};

  xmac_mult #(.HALF(H)) u_mult (
    .a_half   (a_in[H-1:0]),
    .b_half   (b_in[W-1:H]),
    .is_signed(is_signed),
    .prod     (prod)
  );

  xmac_accum #(.WORD(W)) u_accum (
    .prod     (prod),
    .dval     (d_in),
    .is_signed(is_signed),
    .saturate (saturate),
    .result   (res),
    .ovf      (ovf)
  );

  always_comb begin
    so_base         = so_clear ? 1'b0 : so;
    so_next         = so_base | (start & rec_ov & ovf);
    cond_next.neg   = res[W-1];
    cond_next.pos   = !res[W-1] && (res != '0);
    cond_next.zero  = (res == '0);
    cond_next.sumov = so_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      d_out <= '0;
      ov    <= 1'b0;
      so    <= 1'b0;
      cond  <= '0;
    end else begin
      valid <= start;
      so    <= so_next;
      if (start) begin
        d_out <= res;
        if (rec_ov)   ov   <= ovf;
        if (rec_cond) cond <= cond_next;
      end
    end
  end

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> valid);
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    !start |=> !valid);
  a_r10_hold_result: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(d_out));
  a_r7_ov_kept: assert property (@(posedge clk) disable iff (rst)
    !(start && rec_ov) |=> $stable(ov));
  a_r7_so_sticky: assert property (@(posedge clk) disable iff (rst)
    so && !so_clear |=> so);
  a_r7_ov_sets_so: assert property (@(posedge clk) disable iff (rst)
    start && rec_ov |=> (!ov || so));
  a_r8_so_clear: assert property (@(posedge clk) disable iff (rst)
    so_clear && !(start && rec_ov) |=> !so);
  a_r9_cond_onehot: assert property (@(posedge clk) disable iff (rst)
    start && rec_cond |=> $countones(cond[3:1]) == 1);
  a_r9_cond_so_copy: assert property (@(posedge clk) disable iff (rst)
    start && rec_cond |=> cond[0] == so);
  a_r9_cond_kept: assert property (@(posedge clk) disable iff (rst)
    !(start && rec_cond) |=> $stable(cond));
endmodule

// File: tb/xhalf_mac_bench.sv
`timescale 1ns/1ps
module xhalf_mac_bench;
  localparam int N = 12;
  // mode: [1] = signed, [0] = saturate
  localparam logic [31:0] TA[N] = '{32'h0000_0003, 32'hFFFF_0002, 32'h0000_FFFF, 32'h0000_8000,
    32'h0000_8000, 32'h0000_8000, 32'h0000_8000, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_0002,
    32'h0000_0001, 32'h0000_0004};
  localparam logic [31:0] TB[N] = '{32'h0005_0000, 32'h0007_FFFF, 32'h0003_0000, 32'h7FFF_0000,
    32'h8000_0000, 32'h8000_0000, 32'h7FFF_0000, 32'hFFFF_0000, 32'hFFFF_0000, 32'hFFFE_0000,
    32'h0001_0000, 32'h0004_0000};
  localparam logic [31:0] TD[N] = '{32'h0000_0010, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000,
    32'h7FFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0002_0000, 32'h0002_0000, 32'h0000_0004,
    32'hFFFF_FFFE, 32'hFFFF_FFF0};
  localparam logic [1:0] TM[N] = '{2'b00, 2'b00, 2'b10, 2'b10, 2'b10, 2'b11, 2'b11, 2'b01,
    2'b00, 2'b11, 2'b01, 2'b10};
  localparam logic [31:0] TE[N] = '{32'h0000_001F, 32'h0000_000E, 32'h0000_000D, 32'hC000_8000,
    32'hBFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000,
    32'hFFFF_FFFF, 32'h0000_0000};
  localparam logic TO[N] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam string TR[N] = '{"R3", "R1", "R2", "R2", "R6", "R4", "R4", "R5", "R3", "R4", "R5", "R2"};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [31:0] a_in = '0, b_in = '0, d_in = '0;
  logic is_signed = 1'b0, saturate = 1'b0, rec_ov = 1'b0, rec_cond = 1'b0, so_clear = 1'b0;
  logic valid, ov, so;
  logic [31:0] d_out;
  logic [3:0] cond;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  xhalf_mac u_xhalf_mac (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in), .d_in(d_in),
    .is_signed(is_signed), .saturate(saturate), .rec_ov(rec_ov), .rec_cond(rec_cond),
    .so_clear(so_clear), .valid(valid), .d_out(d_out), .ov(ov), .so(so), .cond(cond)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] cond_of(input logic [31:0] r, input logic s);
    return {r[31], !r[31] && (r != 0), r == 0, s};
  endfunction

  task automatic op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] d,
                    input logic [1:0] mode, input logic rov, input logic rcd, input logic clr);
    @(negedge clk);
    a_in = a; b_in = b; d_in = d;
    is_signed = mode[1]; saturate = mode[0];
    rec_ov = rov; rec_cond = rcd; so_clear = clr; start = 1'b1;
    @(negedge clk);
    start = 1'b0; so_clear = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid", {31'b0, valid}, 32'h0);
    chk("R11 d_out", d_out, 32'h0);
    chk("R11 flags", {27'b0, ov, so, cond}, 32'h0);
    rst = 1'b0;

    // table walk: clear so each time, so so == ov afterwards
    for (int i = 0; i < N; i++) begin
      op(TA[i], TB[i], TD[i], TM[i], 1'b1, 1'b1, 1'b1);
      chk({TR[i], " d_out"}, d_out, TE[i]);
      chk("R6 ov", {31'b0, ov}, {31'b0, TO[i]});
      chk("R9 cond", {28'b0, cond}, {28'b0, cond_of(TE[i], TO[i])});
      chk("R10 valid", {31'b0, valid}, 32'h1);
    end

    // R10: valid drops, result held while inputs change without start
    @(negedge clk);
    a_in = 32'h1234_5678; d_in = 32'h0; is_signed = 1'b1;
    chk("R10 valid low", {31'b0, valid}, 32'h0);
    @(negedge clk);
    chk("R10 hold", d_out, TE[N-1]);

    // R1: upper half of A and lower half of B are ignored
    op(32'hABCD_0003, 32'h0005_9876, 32'h0000_0010, 2'b00, 1'b0, 1'b0, 1'b0);
    chk("R1 ignored halves", d_out, 32'h0000_001F);

    // R8: clear so, then R7: overflow without recording leaves ov/so
    op(32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 1'b1, 1'b0, 1'b0);
    chk("R7 so set", {31'b0, so}, 32'h1);
    @(negedge clk); so_clear = 1'b1;
    @(negedge clk); so_clear = 1'b0;
    chk("R8 so cleared", {31'b0, so}, 32'h0);
    chk("R8 ov kept", {31'b0, ov}, 32'h1);
    op(32'h0000_0001, 32'h0001_0000, 32'h0, 2'b00, 1'b1, 1'b0, 1'b0);
    chk("R7 ov cleared", {31'b0, ov}, 32'h0);
    op(32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 1'b0, 1'b1, 1'b0);
    chk("R7 no record ov", {31'b0, ov}, 32'h0);
    chk("R7 no record so", {31'b0, so}, 32'h0);
    chk("R9 cond neg", {28'b0, cond}, 32'h8);
    op(32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 2'b11, 1'b1, 1'b0, 1'b0);
    chk("R7 ov set", {31'b0, ov}, 32'h1);
    chk("R6 sat value", d_out, 32'h7FFF_FFFF);
    // sticky: non-overflowing recorded op keeps so
    op(32'h0000_0001, 32'h0001_0000, 32'h0, 2'b10, 1'b1, 1'b1, 1'b0);
    chk("R7 ov low", {31'b0, ov}, 32'h0);
    chk("R7 so sticky", {31'b0, so}, 32'h1);
    chk("R9 cond pos+so", {28'b0, cond}, 32'h5);
    // R9: rec_cond=0 leaves cond
    op(32'h0, 32'h0, 32'h0, 2'b10, 1'b0, 1'b0, 1'b0);
    chk("R9 cond kept", {28'b0, cond}, 32'h5);
    // R8: clear together with a recording overflowing start
    op(32'h0000_8000, 32'h8000_0000, 32'h7FFF_FFFF, 2'b10, 1'b1, 1'b1, 1'b1);
    chk("R8 clear+set so", {31'b0, so}, 32'h1);
    op(32'h0, 32'h0, 32'h0, 2'b10, 1'b1, 1'b1, 1'b1);
    chk("R8 clear+noov so", {31'b0, so}, 32'h0);
    chk("R9 zero", {28'b0, cond}, 32'h2);

    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end
endmodule